// File: doc/BRIEF.md
# USB Endpoint Interrupt Event Generator

This block turns transaction-outcome strobes from a low-speed USB serial interface engine into interrupt requests for two endpoints: a control endpoint (endpoint 0) and one non-control endpoint (endpoint 1). Each cycle, the engine reports what happened on each endpoint. The possible outcomes are:

- a SETUP was taken in;
- a zero-length status-stage packet went out;
- OUT data was stored, with a flag that says whether the CRC was good;
- a NAK or STALL was returned to an IN or to an OUT;
- an ACK came back after an IN.

The engine also reports two mode flags per endpoint: whether the endpoint is armed to accept SETUP, and whether it is in an ACK-OUT mode.

The two endpoints react to different sets of outcomes. The block decides, per endpoint, whether the reported outcomes count as an interrupt cause. It then gates that decision with a per-endpoint enable bit held in a small register. The register is written and read through an 8-bit address/data port. A qualified cause produces a one-clock request pulse towards the CPU interrupt controller.

Top module: `usb_ep_irq_gen`

## Requirements
- R1: After reset, both enable bits are 0, `ep_irq` is 2'b00, and a read at address 0x21 returns 0x00.
- R2: A write strobe with address 0x21 loads `reg_wdata[1:0]` into the enable bits. Bit 0 enables endpoint 0 and bit 1 enables endpoint 1. A read at 0x21 returns {6'b0, enables}. A read at any other address returns 0x00. Writes to other addresses leave the enables unchanged.
- R3: Endpoint 0 requests an interrupt for a received SETUP only while its setup-armed flag is 1. A SETUP strobe on endpoint 1 never causes an interrupt.
- R4: Endpoint 0 requests an interrupt when a zero-length status-stage packet has been sent. The same strobe on endpoint 1 has no effect.
- R5: On either endpoint, stored OUT data with a good CRC causes an interrupt. OUT data with a bad CRC causes none when the endpoint is not in an ACK-OUT mode.
- R6: On an endpoint in an ACK-OUT mode, stored OUT data causes an interrupt whatever the CRC flag says.
- R7: On either endpoint, a NAK or STALL sent in reply to an IN or to an OUT causes an interrupt.
- R8: An ACK received after an IN causes an interrupt on endpoint 1 and none on endpoint 0.
- R9: `ep_irq[i]` is high for exactly the one clock that follows each cycle in which endpoint i had a cause while its enable was 1. Causes that arrive while the endpoint is disabled are discarded and never delivered later.
- R10: When a register write and a cause land in the same cycle, the enable value held before the write decides whether that cause is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| setup_rx | input | 2 | Per endpoint: SETUP token accepted this cycle |
| setup_armed | input | 2 | Per endpoint: mode accepts SETUP |
| zlp_status_tx | input | 2 | Per endpoint: zero-length status packet sent |
| out_done | input | 2 | Per endpoint: OUT data written to the FIFO |
| out_crc_good | input | 2 | Per endpoint: CRC of that OUT data was valid |
| ack_out_mode | input | 2 | Per endpoint: endpoint is in an ACK-OUT mode |
| hs_nak_stall_in | input | 2 | Per endpoint: NAK or STALL sent to a host IN |
| hs_nak_stall_out | input | 2 | Per endpoint: NAK or STALL sent to a host OUT |
| in_ack_rx | input | 2 | Per endpoint: ACK received after an IN |
| ep_irq | output | 2 | Per endpoint: one-clock interrupt request |

## Verification
An enable-register write and an endpoint cause can land in the same clock, and the result depends on which enable value the gate sees. The bench provokes this by issuing a write that clears the enables while a NAK strobe is present, and again a write that sets them while an OUT strobe is present. The scoreboard expects the pulse in the first case and no pulse in the second, because it judges each cause against the enable value held before the write. The bench then sends a follow-up strobe to confirm that the new enable value governs from the next cycle on.

// File: rtl/usb_ep_irq_pkg.sv
// Package: shared types and constants for the endpoint interrupt generator.
// Assumes the engine drives each strobe high for a single cycle per outcome.
package usb_ep_irq_pkg;

    // Outcome strobes and mode flags reported for one endpoint in one cycle.
    typedef struct packed {
        logic setup_rx;
        logic setup_armed;
        logic zlp_status_tx;
        logic out_done;
        logic out_crc_good;
        logic ack_out_mode;
        logic nak_stall_in;
        logic nak_stall_out;
        logic in_ack_rx;
    } ep_outcome_t;

    // Address of the enable register in the block's register window.
    localparam logic [7:0] EP_IRQ_EN_ADDR = 8'h21;

endpackage

// File: rtl/ep_irq_enable_reg.sv
// Module: per-endpoint enable register.
// It holds one enable bit per endpoint. A write to EN_ADDR loads the low
// NUM_EP data bits. Reads are combinational, and every bit above the enables
// reads as zero.
// Assumes reg_wr_en is a single-cycle strobe that is already qualified.
module ep_irq_enable_reg #(
    parameter int          NUM_EP  = 2,
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_EP-1:0] en_q
);

    localparam int PAD_W = DATA_W - NUM_EP;

    logic hit;

    // Address decode shared by the read and write paths.
    assign hit = (reg_addr == EN_ADDR);

    // Enable storage: cleared by reset, loaded from the low data bits on a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (reg_wr_en && hit) begin
            en_q <= reg_wdata[NUM_EP-1:0];
        end
    end

    // Read mux: enable bits with the reserved bits zero-filled; zero on a miss.
    always_comb begin
        if (hit) begin
            reg_rdata = {{PAD_W{1'b0}}, en_q};
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/ep_irq_classify.sv
// Module: cause classifier for a single endpoint.
// It decides from this cycle's outcome strobes whether the endpoint has an
// interrupt cause. IS_CTRL selects the control-endpoint rule set (SETUP,
// status ZLP) or the data-endpoint rule set (ACK after IN). The OUT rule is
// shared by both: OUT data counts if its CRC is good, or if the endpoint is
// in an ACK-OUT mode.
// Assumes the outcome fields are valid for the current cycle only.
module ep_irq_classify
    import usb_ep_irq_pkg::*;
#(
    parameter bit IS_CTRL = 1'b0
) (
    input  ep_outcome_t ev,
    output logic        cause
);

    logic out_cause;
    logic hs_cause;

    // OUT qualification: good data, or any data while in an ACK-OUT mode.
    always_comb begin
        out_cause = ev.out_done && (ev.out_crc_good || ev.ack_out_mode);
    end

    // Handshake qualification: a NAK or STALL sent in either direction.
    always_comb begin
        hs_cause = ev.nak_stall_in || ev.nak_stall_out;
    end

    generate
        if (IS_CTRL) begin : g_ctrl
            // Control rule set: armed SETUP, status ZLP, OUT, handshake.
            always_comb begin
                cause = (ev.setup_rx && ev.setup_armed) || ev.zlp_status_tx
                        || out_cause || hs_cause;
            end
        end else begin : g_data
            // Data rule set: OUT, handshake, ACK after IN.
            always_comb begin
                cause = out_cause || hs_cause || ev.in_ack_rx;
            end
        end
    endgenerate

endmodule

// File: rtl/ep_irq_pulse.sv
// Module: output stage that gates causes with the enables.
// It registers cause AND enable, so each request is one clock wide and comes
// one cycle after its cause. A cause seen while the endpoint is disabled is
// discarded and never stored.
// Assumes en carries the value held before any write in the same cycle.
module ep_irq_pulse #(
    parameter int NUM_EP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] cause,
    input  logic [NUM_EP-1:0] en,
    output logic [NUM_EP-1:0] irq
);

    // Request register: one-cycle pulse per enabled cause, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= '0;
        end else begin
            irq <= cause & en;
        end
    end

endmodule

// File: rtl/usb_ep_irq_gen.sv
// Module: top of the USB endpoint interrupt event generator.
// It builds one outcome bundle per endpoint and runs a classifier for each
// one. A classifier uses the control rule set when the endpoint's bit in
// CTRL_MASK is set. The causes are gated by the enable register, and the
// output stage registers them as one-clock requests.
// Assumes the outcome inputs are indexed by endpoint number.
module usb_ep_irq_gen
    import usb_ep_irq_pkg::*;
#(
    parameter int                NUM_EP    = 2,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [NUM_EP-1:0] CTRL_MASK = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_EP-1:0] setup_rx,
    input  logic [NUM_EP-1:0] setup_armed,
    input  logic [NUM_EP-1:0] zlp_status_tx,
    input  logic [NUM_EP-1:0] out_done,
    input  logic [NUM_EP-1:0] out_crc_good,
    input  logic [NUM_EP-1:0] ack_out_mode,
    input  logic [NUM_EP-1:0] hs_nak_stall_in,
    input  logic [NUM_EP-1:0] hs_nak_stall_out,
    input  logic [NUM_EP-1:0] in_ack_rx,
    output logic [NUM_EP-1:0] ep_irq
);

    logic [NUM_EP-1:0] en_bits;
    logic [NUM_EP-1:0] cause;
    ep_outcome_t       ev [NUM_EP];

    // Enable register with its read path.
    ep_irq_enable_reg #(
        .NUM_EP (NUM_EP),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EN_ADDR(ADDR_W'(EP_IRQ_EN_ADDR))
    ) u_en_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr_en(reg_wr_en),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .en_q     (en_bits)
    );

    generate
        for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
            // Bundle the endpoint's strobes and mode flags.
            always_comb begin
                ev[i].setup_rx      = setup_rx[i];
                ev[i].setup_armed   = setup_armed[i];
                ev[i].zlp_status_tx = zlp_status_tx[i];
                ev[i].out_done      = out_done[i];
                ev[i].out_crc_good  = out_crc_good[i];
                ev[i].ack_out_mode  = ack_out_mode[i];
                ev[i].nak_stall_in  = hs_nak_stall_in[i];
                ev[i].nak_stall_out = hs_nak_stall_out[i];
                ev[i].in_ack_rx     = in_ack_rx[i];
            end

            ep_irq_classify #(
                .IS_CTRL(CTRL_MASK[i])
            ) u_classify (
                .ev   (ev[i]),
                .cause(cause[i])
            );
        end
    endgenerate

    // Gate and register the causes into request pulses.
    ep_irq_pulse #(
        .NUM_EP(NUM_EP)
    ) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .cause(cause),
        .en   (en_bits),
        .irq  (ep_irq)
    );

endmodule

// File: rtl/usb_ep_irq_chk.sv
// Checker: temporal properties of the interrupt generator, bound to the top.
// It assumes endpoint 0 is the control endpoint and endpoint 1 the data endpoint.
module usb_ep_irq_chk #(
    parameter int NUM_EP = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NUM_EP-1:0] en,
    input logic [NUM_EP-1:0] setup_rx,
    input logic [NUM_EP-1:0] zlp_status_tx,
    input logic [NUM_EP-1:0] out_done,
    input logic [NUM_EP-1:0] ack_out_mode,
    input logic [NUM_EP-1:0] hs_nak_stall_in,
    input logic [NUM_EP-1:0] hs_nak_stall_out,
    input logic [NUM_EP-1:0] in_ack_rx,
    input logic [NUM_EP-1:0] ep_irq
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ep_irq == '0) && (en == '0));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_EP] == '0);

    // R8
    ep0_no_inack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack_rx[0] && !setup_rx[0] && !zlp_status_tx[0] && !out_done[0]
         && !hs_nak_stall_in[0] && !hs_nak_stall_out[0]) |=> !ep_irq[0]);

    // R8
    ep1_inack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en[1] && in_ack_rx[1]) |=> ep_irq[1]);

    generate
        for (genvar i = 0; i < NUM_EP; i++) begin : g_ep_chk
            // R9
            irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ep_irq[i] |-> $past(en[i]));

            // R6
            ack_out_any_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en[i] && out_done[i] && ack_out_mode[i]) |=> ep_irq[i]);

            // R7
            handshake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en[i] && (hs_nak_stall_in[i] || hs_nak_stall_out[i])) |=> ep_irq[i]);
        end
    endgenerate

endmodule

bind usb_ep_irq_gen usb_ep_irq_chk #(
    .NUM_EP(NUM_EP),
    .DATA_W(DATA_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_rdata       (reg_rdata),
    .en              (en_bits),
    .setup_rx        (setup_rx),
    .zlp_status_tx   (zlp_status_tx),
    .out_done        (out_done),
    .ack_out_mode    (ack_out_mode),
    .hs_nak_stall_in (hs_nak_stall_in),
    .hs_nak_stall_out(hs_nak_stall_out),
    .in_ack_rx       (in_ack_rx),
    .ep_irq          (ep_irq)
);

// File: tb/usb_ep_irq_gen_bench.sv
// Scoreboard bench. The driver task applies one cycle of stimulus and queues
// the expected ep_irq for that cycle. The monitor pops each entry just after
// the clock edge that produces the result and compares it.
module usb_ep_irq_gen_bench;

    typedef struct packed {
        logic [1:0] setup;
        logic [1:0] armed;
        logic [1:0] zlp;
        logic [1:0] outd;
        logic [1:0] crc;
        logic [1:0] ackm;
        logic [1:0] nin;
        logic [1:0] nout;
        logic [1:0] inack;
    } stim_t;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h21;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    stim_t      s = '0;
    logic [1:0] ep_irq;

    sb_item_t   sb_q[$];
    logic [1:0] en_m = 2'b00;
    int         n_checks = 0;
    int         n_fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    usb_ep_irq_gen u_usb_ep_irq_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr_en       (reg_wr_en),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .setup_rx        (s.setup),
        .setup_armed     (s.armed),
        .zlp_status_tx   (s.zlp),
        .out_done        (s.outd),
        .out_crc_good    (s.crc),
        .ack_out_mode    (s.ackm),
        .hs_nak_stall_in (s.nin),
        .hs_nak_stall_out(s.nout),
        .in_ack_rx       (s.inack),
        .ep_irq          (ep_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Expected cause per endpoint, taken from the requirement rules.
    function automatic logic [1:0] cause_m(input stim_t t);
        logic [1:0] c;
        c[0] = (t.setup[0] & t.armed[0]) | t.zlp[0] | (t.outd[0] & (t.crc[0] | t.ackm[0]))
               | t.nin[0] | t.nout[0];
        c[1] = (t.outd[1] & (t.crc[1] | t.ackm[1])) | t.nin[1] | t.nout[1] | t.inack[1];
        return c;
    endfunction

    // Driver: one cycle of stimulus plus an optional register write.
    task automatic step(input stim_t t, input logic wr, input logic [7:0] a,
                        input logic [7:0] d, input string tag);
        sb_item_t it;
        @(negedge clk);
        s         = t;
        reg_wr_en = wr;
        reg_addr  = a;
        reg_wdata = d;
        it.exp    = cause_m(t) & en_m;
        it.tag    = tag;
        sb_q.push_back(it);
        if (wr && a == 8'h21) en_m = d[1:0];
    endtask

    task automatic idle(input string tag);
        step('0, 1'b0, 8'h21, 8'h00, tag);
    endtask

    // Monitor: compare each result just after the edge that registers it.
    always @(posedge clk) begin
        #2;
        if (rst_n && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, {6'b0, ep_irq}, {6'b0, it.exp});
        end
    end

    task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        s         = '0;
        reg_wr_en = 1'b0;
        reg_addr  = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        stim_t t;
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while held in reset
        check("R1 irq in reset", {6'b0, ep_irq}, 8'h00);
        check("R1 rdata in reset", reg_rdata, 8'h00);
        rst_n = 1'b1;
        read_chk(8'h21, 8'h00, "R1 rdata after reset");

        // R2: register writes and reads
        step('0, 1'b1, 8'h21, 8'hFF, "R2 write ff");
        read_chk(8'h21, 8'h03, "R2 readback reserved zero");
        step('0, 1'b1, 8'h20, 8'h00, "R2 write other addr");
        read_chk(8'h21, 8'h03, "R2 other addr no effect");
        read_chk(8'h20, 8'h00, "R2 read other addr");
        step('0, 1'b1, 8'h21, 8'h00, "R2 clear");
        read_chk(8'h21, 8'h00, "R2 cleared");

        // R9: causes while disabled are dropped, not latched
        t = '0; t.nin = 2'b11;
        step(t, 1'b0, 8'h21, 8'h00, "R9 disabled drop");
        step('0, 1'b1, 8'h21, 8'h03, "R9 enable");
        idle("R9 no late delivery");
        idle("R9 idle");

        // R3: SETUP
        t = '0; t.setup = 2'b11; t.armed = 2'b11;
        step(t, 1'b0, 8'h21, 8'h00, "R3 armed setup");
        t = '0; t.setup = 2'b01;
        step(t, 1'b0, 8'h21, 8'h00, "R3 unarmed setup");
        // R4: status ZLP
        t = '0; t.zlp = 2'b11;
        step(t, 1'b0, 8'h21, 8'h00, "R4 status zlp");
        // R5: OUT with good CRC, then bad CRC outside ACK-OUT mode
        t = '0; t.outd = 2'b11; t.crc = 2'b11;
        step(t, 1'b0, 8'h21, 8'h00, "R5 out good crc");
        t = '0; t.outd = 2'b11;
        step(t, 1'b0, 8'h21, 8'h00, "R5 out bad crc");
        // R6: ACK-OUT mode ignores CRC
        t = '0; t.outd = 2'b11; t.ackm = 2'b11;
        step(t, 1'b0, 8'h21, 8'h00, "R6 ack-out bad crc");
        t = '0; t.outd = 2'b10; t.ackm = 2'b10; t.crc = 2'b10;
        step(t, 1'b0, 8'h21, 8'h00, "R6 ack-out good crc ep1");
        // R7: NAK/STALL in both directions, back to back (R9 pulse per cycle)
        t = '0; t.nin = 2'b01; t.nout = 2'b10;
        step(t, 1'b0, 8'h21, 8'h00, "R7 nak mixed");
        t = '0; t.nout = 2'b01; t.nin = 2'b10;
        step(t, 1'b0, 8'h21, 8'h00, "R7 nak swapped");
        idle("R9 pulse ends");
        // R8: ACK after IN
        t = '0; t.inack = 2'b11;
        step(t, 1'b0, 8'h21, 8'h00, "R8 in ack");
        t = '0; t.inack = 2'b01;
        step(t, 1'b0, 8'h21, 8'h00, "R8 ep0 in ack ignored");

        // R10: write and cause in the same cycle
        t = '0; t.nin = 2'b11;
        step(t, 1'b1, 8'h21, 8'h00, "R10 clear same cycle");
        step(t, 1'b0, 8'h21, 8'h00, "R10 after clear");
        t = '0; t.outd = 2'b11; t.crc = 2'b11;
        step(t, 1'b1, 8'h21, 8'h02, "R10 set same cycle");
        step(t, 1'b0, 8'h21, 8'h00, "R10 after set ep1 only");
        idle("R10 idle");

        // R9: mixed stimulus against the rule model
        lfsr = 16'hACE1;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            t = stim_t'({lfsr[1:0] & lfsr[9:8], lfsr});
            t.nin = t.nin & {lfsr[3], lfsr[5]};
            if (k % 9 == 0) step(t, 1'b1, 8'h21, {6'b0, lfsr[7:6]}, "R9 mixed write");
            else step(t, 1'b0, 8'h21, 8'h00, "R9 mixed");
        end
        idle("R9 drain");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule